// File: doc/BRIEF.md
# Cascaded 96-Source Interrupt Controller

This block gathers interrupt requests from three groups of 32 sources and turns them into one CPU interrupt line and one vector register. There are 64 internal, level-sensitive request lines, held in a low and a high main cause word, and 32 general-purpose pins. Each pin latches a cause bit on a rising edge. The pin group does not go straight to the CPU. Four summary bits in the high cause word stand for it, one per group of eight pins, and the pin cause word is searched only when one of those summary bits wins the high-word search.

Software uses a small register-mapped bus. Through it, software reads the cause words and the vector, and reads or writes the three mask words. It can also enable or disable a single source by number, and it clears pin cause bits by writing zeros over them. Source numbers run 0–31 for the low word, 32–63 for the high word and 64–95 for the pins, with pin n being source 64+n. The vector holds the lowest-numbered enabled pending source. When nothing can be served, it holds the spurious code 0xFFFF_FFFE (−2).

Top module: `irqc_top`

## Requirements
- R1: A synchronous active-high reset leaves the low and pin masks at 0 and the high mask at 0x0F00_0000 (cascade summaries enabled). It also leaves all cause bits at 0, `irq_o` low and the vector at 0xFFFF_FFFE.
- R2: The low cause word (address 0) follows `src_lo_i` with one cycle of delay. The high cause word (address 1) follows `src_hi_i` the same way, except in bits 24–27. Bit 24+k reads as the OR of pin cause bits 8k to 8k+7, and `src_hi_i[27:24]` is ignored.
- R3: A rising edge on `gp_pin_i[n]` sets pin cause bit n (address 2) on the next clock, and the bit holds until software clears it. A pin that is already high when reset is released latches nothing.
- R4: A write to address 2 clears every pin cause bit written as 0 and leaves bits written as 1 unchanged. A rising edge in the same cycle as its clear leaves the bit set.
- R5: The search considers only the low cause bits under the constant 0x3DFF_FFFE and only the high cause bits under 0x0F00_0DB7, whatever their mask bits hold.
- R6: Enabled pending low sources are served first, the lowest bit index winning, and the vector equals that index.
- R7: With no low source eligible, the lowest eligible high bit h wins. For h below 24 the vector is 32+h. For h of 24 or more, the lowest pin bit g that is both pending and unmasked gives vector 64+g.
- R8: The vector is 0xFFFF_FFFE when no source is eligible, and also when a summary bit wins but no unmasked pin cause bit is pending.
- R9: A write to address 7 sets (wdata[7]=1) or clears (wdata[7]=0) one mask bit chosen by the source number in wdata[6:0]. Numbers 0–31 select the low mask, 32–63 bit n−32 of the high mask and 64–95 bit n−64 of the pin mask. Numbers 96–127 change no mask.
- R10: Addresses 3, 4 and 5 read and write the low, high and pin mask words whole.
- R11: `irq_o` is high exactly when the vector is not the spurious code. Both are registered one cycle after the cause and mask state they reflect, and the vector reads at address 6; address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lo_i | input | 32 | Level requests for sources 0–31 |
| src_hi_i | input | 32 | Level requests for sources 32–63 |
| gp_pin_i | input | 32 | Edge-detected general-purpose pins, sources 64–95 |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed register |
| irq_o | output | 1 | Registered interrupt request to the CPU |

## Verification
A request line or pin edge that changes before clock edge k shows in the cause words after edge k, and in `irq_o` and the vector after edge k+1. A mask or command write taken at edge k moves the vector at edge k+1. The bench keeps its own cycle model, updated at each rising edge in the same order, and compares `irq_o` and the vector three time units after every falling edge. Directed register reads are made at least two cycles after the stimulus they look at, when both pipeline stages have settled.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int REG_W        = 32;
    localparam int IDX_W        = $clog2(REG_W);
    localparam int CASC_LSB     = 24;
    localparam int CASC_GROUPS  = 4;
    localparam int GP_PER_GROUP = REG_W / CASC_GROUPS;
    localparam int NUM_SRC      = 3 * REG_W;

    localparam logic [REG_W-1:0] LO_ELIGIBLE = 32'h3DFF_FFFE;
    localparam logic [REG_W-1:0] HI_ELIGIBLE = 32'h0F00_0DB7;
    localparam logic [REG_W-1:0] CASC_BITS   =
        REG_W'(((1 << CASC_GROUPS) - 1) << CASC_LSB);
    localparam logic [REG_W-1:0] HI_MASK_RST = CASC_BITS;
    localparam logic [REG_W-1:0] VEC_SPUR    = 32'hFFFF_FFFE;

    typedef enum logic [2:0] {
        A_CAUSE_LO = 3'd0,
        A_CAUSE_HI = 3'd1,
        A_GP_CAUSE = 3'd2,
        A_MASK_LO  = 3'd3,
        A_MASK_HI  = 3'd4,
        A_MASK_GP  = 3'd5,
        A_VECTOR   = 3'd6,
        A_COMMAND  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic [REG_W-1:0] lo;
        logic [REG_W-1:0] hi;
        logic [REG_W-1:0] gp;
    } word3_t;

    typedef struct packed {
        logic             found;
        logic [IDX_W-1:0] idx;
    } pick_t;

    function automatic pick_t pick_lowest(input logic [REG_W-1:0] v);
        pick_t p;
        p = '0;
        for (int i = REG_W - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.found = 1'b1;
                p.idx   = IDX_W'(i);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/irqc_gp_edge.sv
module irqc_gp_edge
    import irqc_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_keep_i,
    output logic [W-1:0] cause_o
);

    logic [W-1:0] prev_q;
    logic [W-1:0] cause_q;
    logic [W-1:0] rise;
    logic [W-1:0] kept;

    assign rise = pin_i & ~prev_q;
    assign kept = clr_we_i ? (cause_q & clr_keep_i) : cause_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= pin_i;
            cause_q <= '0;
        end else begin
            prev_q  <= pin_i;
            cause_q <= kept | rise;
        end
    end

    assign cause_o = cause_q;

    AST_GP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !clr_we_i |=> ((cause_o & $past(cause_o)) == $past(cause_o))); // R3

    AST_GP_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((cause_o & $past(pin_i & ~prev_q)) == $past(pin_i & ~prev_q))); // R4

endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] src_lo_i,
    input  logic [REG_W-1:0] src_hi_i,
    input  logic [REG_W-1:0] gp_cause_i,
    input  logic [REG_W-1:0] vec_i,
    input  logic             bus_we,
    input  logic [2:0]       bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output word3_t           cause_o,
    output word3_t           mask_o,
    output logic             gp_clr_we_o,
    output logic [REG_W-1:0] gp_clr_keep_o
);

    logic [REG_W-1:0]       lvl_lo_q, lvl_hi_q;
    logic [REG_W-1:0]       mask_lo_q, mask_hi_q, mask_gp_q;
    logic [CASC_GROUPS-1:0] summary;
    logic [REG_W-1:0]       hi_visible;
    logic                   cmd_set;
    logic [1:0]             cmd_bank;
    logic [IDX_W-1:0]       cmd_bit;

    for (genvar g = 0; g < CASC_GROUPS; g++) begin : g_summary
        assign summary[g] = |gp_cause_i[g*GP_PER_GROUP +: GP_PER_GROUP];
    end

    assign hi_visible = (lvl_hi_q & ~CASC_BITS) | (REG_W'(summary) << CASC_LSB);

    assign cmd_set  = bus_wdata[IDX_W+2];
    assign cmd_bank = bus_wdata[IDX_W+1:IDX_W];
    assign cmd_bit  = bus_wdata[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_lo_q  <= '0;
            lvl_hi_q  <= '0;
            mask_lo_q <= '0;
            mask_hi_q <= HI_MASK_RST;
            mask_gp_q <= '0;
        end else begin
            lvl_lo_q <= src_lo_i;
            lvl_hi_q <= src_hi_i;
            if (bus_we) begin
                case (bus_addr)
                    A_MASK_LO: mask_lo_q <= bus_wdata;
                    A_MASK_HI: mask_hi_q <= bus_wdata;
                    A_MASK_GP: mask_gp_q <= bus_wdata;
                    A_COMMAND: begin
                        case (cmd_bank)
                            2'd0:    mask_lo_q[cmd_bit] <= cmd_set;
                            2'd1:    mask_hi_q[cmd_bit] <= cmd_set;
                            2'd2:    mask_gp_q[cmd_bit] <= cmd_set;
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end
        end
    end

    assign gp_clr_we_o   = bus_we && (bus_addr == A_GP_CAUSE);
    assign gp_clr_keep_o = bus_wdata;

    always_comb begin
        case (bus_addr)
            A_CAUSE_LO: bus_rdata = lvl_lo_q;
            A_CAUSE_HI: bus_rdata = hi_visible;
            A_GP_CAUSE: bus_rdata = gp_cause_i;
            A_MASK_LO:  bus_rdata = mask_lo_q;
            A_MASK_HI:  bus_rdata = mask_hi_q;
            A_MASK_GP:  bus_rdata = mask_gp_q;
            A_VECTOR:   bus_rdata = vec_i;
            default:    bus_rdata = '0;
        endcase
    end

    assign cause_o = '{lo: lvl_lo_q, hi: hi_visible, gp: gp_cause_i};
    assign mask_o  = '{lo: mask_lo_q, hi: mask_hi_q, gp: mask_gp_q};

    AST_MASK_RESET: assert property (@(posedge clk)
        $past(rst) |-> (mask_hi_q == HI_MASK_RST && mask_lo_q == '0 && mask_gp_q == '0)); // R1

    AST_CMD_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_COMMAND && cmd_bank == 2'd3)
        |=> $stable({mask_lo_q, mask_hi_q, mask_gp_q})); // R9

endmodule

// File: rtl/irqc_resolve.sv
module irqc_resolve
    import irqc_pkg::*;
(
    input  word3_t           cause_i,
    input  word3_t           mask_i,
    output logic [REG_W-1:0] vec_o,
    output logic             pend_o
);

    logic [REG_W-1:0] lo_act, hi_act, gp_act;
    pick_t            lo_p, hi_p, gp_p;

    assign lo_act = cause_i.lo & LO_ELIGIBLE & mask_i.lo;
    assign hi_act = cause_i.hi & HI_ELIGIBLE & mask_i.hi;
    assign gp_act = cause_i.gp & mask_i.gp;

    assign lo_p = pick_lowest(lo_act);
    assign hi_p = pick_lowest(hi_act);
    assign gp_p = pick_lowest(gp_act);

    always_comb begin
        vec_o = VEC_SPUR;
        if (lo_p.found) begin
            vec_o = REG_W'(lo_p.idx);
        end else if (hi_p.found) begin
            if (int'(hi_p.idx) >= CASC_LSB) begin
                if (gp_p.found) begin
                    vec_o = REG_W'(gp_p.idx) + REG_W'(2 * REG_W);
                end
            end else begin
                vec_o = REG_W'(hi_p.idx) + REG_W'(REG_W);
            end
        end
    end

    assign pend_o = (|lo_act)
                  | (|(hi_act & ~CASC_BITS))
                  | ((|(hi_act & CASC_BITS)) & (|gp_act));

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] src_lo_i,
    input  logic [31:0] src_hi_i,
    input  logic [31:0] gp_pin_i,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o
);

    word3_t           cause, mask;
    logic [REG_W-1:0] gp_cause;
    logic             gp_clr_we;
    logic [REG_W-1:0] gp_clr_keep;
    logic [REG_W-1:0] vec_d, vec_q;
    logic             pend_d, irq_q;

    irqc_gp_edge #(.W(REG_W)) u_gp_edge (
        .clk        (clk),
        .rst        (rst),
        .pin_i      (gp_pin_i),
        .clr_we_i   (gp_clr_we),
        .clr_keep_i (gp_clr_keep),
        .cause_o    (gp_cause)
    );

    irqc_regfile u_regs (
        .clk           (clk),
        .rst           (rst),
        .src_lo_i      (src_lo_i),
        .src_hi_i      (src_hi_i),
        .gp_cause_i    (gp_cause),
        .vec_i         (vec_q),
        .bus_we        (bus_we),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .cause_o       (cause),
        .mask_o        (mask),
        .gp_clr_we_o   (gp_clr_we),
        .gp_clr_keep_o (gp_clr_keep)
    );

    irqc_resolve u_resolve (
        .cause_i (cause),
        .mask_i  (mask),
        .vec_o   (vec_d),
        .pend_o  (pend_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= VEC_SPUR;
            irq_q <= 1'b0;
        end else begin
            vec_q <= vec_d;
            irq_q <= pend_d;
        end
    end

    assign irq_o = irq_q;

    AST_IRQ_VEC_AGREE: assert property (@(posedge clk) disable iff (rst)
        irq_q == (vec_q != VEC_SPUR)); // R11

    AST_LOW_FIRST: assert property (@(posedge clk) disable iff (rst)
        (|(cause.lo & mask.lo & LO_ELIGIBLE)) |=> (vec_q < REG_W'(REG_W))); // R6

    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst)
        (vec_q < REG_W'(NUM_SRC)) || (vec_q == VEC_SPUR)); // R7

endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;

    localparam logic [31:0] SPUR   = 32'hFFFF_FFFE;
    localparam logic [31:0] LO_OK  = 32'h3DFF_FFFE;
    localparam logic [31:0] HI_OK  = 32'h0F00_0DB7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_lo = '0, src_hi = '0, gpin = '0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd6;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    irqc_top dut (
        .clk(clk), .rst(rst), .src_lo_i(src_lo), .src_hi_i(src_hi),
        .gp_pin_i(gpin), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    // Behavioural reference state
    logic [31:0] m_mlo, m_mhi, m_mgp, m_clo, m_chi, m_gc, m_gprev;
    logic [31:0] e_vec;
    logic        e_irq;

    function automatic logic [31:0] hi_seen(input logic [31:0] lvl, input logic [31:0] gc);
        logic [31:0] r;
        r = lvl & 32'hF0FF_FFFF;
        for (int k = 0; k < 4; k++)
            if (((gc >> (8 * k)) & 32'hFF) != 0) r[24 + k] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] ref_vec(input logic [31:0] clo, chi, gc, mlo, mhi, mgp);
        for (int i = 0; i < 32; i++)
            if (clo[i] && LO_OK[i] && mlo[i]) return i;
        for (int i = 0; i < 32; i++) begin
            if (chi[i] && HI_OK[i] && mhi[i]) begin
                if (i < 24) return 32 + i;
                for (int g = 0; g < 32; g++)
                    if (gc[g] && mgp[g]) return 64 + g;
                return SPUR;
            end
        end
        return SPUR;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mlo = '0; m_mhi = 32'h0F00_0000; m_mgp = '0;
            m_clo = '0; m_chi = '0; m_gc = '0; m_gprev = gpin;
            e_vec = SPUR; e_irq = 1'b0;
        end else begin
            e_vec = ref_vec(m_clo, hi_seen(m_chi, m_gc), m_gc, m_mlo, m_mhi, m_mgp);
            e_irq = (e_vec != SPUR);
            if (bus_we) begin
                case (bus_addr)
                    3'd3: m_mlo = bus_wdata;
                    3'd4: m_mhi = bus_wdata;
                    3'd5: m_mgp = bus_wdata;
                    3'd7: begin
                        if (bus_wdata[6:0] < 32)      m_mlo[bus_wdata[4:0]] = bus_wdata[7];
                        else if (bus_wdata[6:0] < 64) m_mhi[bus_wdata[4:0]] = bus_wdata[7];
                        else if (bus_wdata[6:0] < 96) m_mgp[bus_wdata[4:0]] = bus_wdata[7];
                    end
                    default: ;
                endcase
            end
            if (bus_we && bus_addr == 3'd2) m_gc = m_gc & bus_wdata;
            m_gc = m_gc | (gpin & ~m_gprev);
            m_gprev = gpin;
            m_clo = src_lo;
            m_chi = src_hi;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // Every-cycle comparison of irq_o and the vector (R6 R7 R8 R11)
    always @(negedge clk) begin
        #3;
        if (!rst && bus_addr == 3'd6) begin
            chk("R11 irq_o per cycle", {31'b0, irq_o}, {31'b0, e_irq});
            chk("R6/R7/R8 vector per cycle", bus_rdata, e_vec);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 3'd6;
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        bus_addr = 3'd6;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        gpin[31] = 1'b1;  // high through reset release: must not latch (R3)
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 irq_o after reset", {31'b0, irq_o}, 32'd0);
        rd("R1 low mask reset", 3'd3, 32'h0);
        rd("R1 high mask reset", 3'd4, 32'h0F00_0000);
        rd("R1 pin mask reset", 3'd5, 32'h0);
        rd("R1 vector reset", 3'd6, SPUR);
        settle();
        rd("R3 no latch from reset-high pin", 3'd2, 32'h0);

        // low sources
        wr(3'd7, 32'h80 | 5);
        rd("R9 enable source 5", 3'd3, 32'h20);
        @(negedge clk); src_lo = (32'h1 << 5) | (32'h1 << 9);
        settle();
        rd("R6 lowest low source wins", 3'd6, 32'd5);
        chk("R11 irq_o high", {31'b0, irq_o}, 32'd1);
        wr(3'd3, 32'h220);
        @(negedge clk); src_lo = 32'h1 << 9;
        settle();
        rd("R6 vector follows remaining source", 3'd6, 32'd9);
        rd("R2 low cause word", 3'd0, 32'h200);
        rd("R10 low mask write", 3'd3, 32'h220);

        // ineligible low bit 0
        wr(3'd3, 32'h221);
        @(negedge clk); src_lo = 32'h1;
        settle();
        rd("R5 low bit 0 ignored", 3'd6, SPUR);
        chk("R5 irq_o low", {31'b0, irq_o}, 32'd0);

        // low beats high
        wr(3'd7, 32'h80 | 33);
        @(negedge clk); src_lo = 32'h1 << 9; src_hi = 32'h2;
        settle();
        rd("R6 low served before high", 3'd6, 32'd9);
        @(negedge clk); src_lo = '0;
        settle();
        rd("R7 high source vector", 3'd6, 32'd33);

        // ineligible high bit 3, level on summary bit ignored
        wr(3'd7, 32'h80 | 35);
        @(negedge clk); src_hi = (32'h1 << 3) | (32'h1 << 25);
        settle();
        rd("R5 high bit 3 ignored", 3'd6, SPUR);
        rd("R2 summary bits ignore level input", 3'd1, 32'h8);

        // pin cascade
        @(negedge clk); src_hi = '0;
        wr(3'd7, 32'h80 | 74);
        rd("R9 pin mask via command", 3'd5, 32'h400);
        @(negedge clk); gpin[10] = 1'b1;
        @(negedge clk); gpin[10] = 1'b0;
        settle();
        rd("R3 pin edge latched", 3'd2, 32'h400);
        rd("R7 cascaded vector", 3'd6, 32'd74);
        rd("R2 summary bit 25", 3'd1, 32'h0200_0000);
        repeat (3) @(negedge clk);
        rd("R3 cause holds after pin falls", 3'd2, 32'h400);

        @(negedge clk); gpin[20] = 1'b1;
        @(negedge clk); gpin[20] = 1'b0;
        wr(3'd2, ~(32'h1 << 10));
        settle();
        rd("R4 zero clears bit 10", 3'd2, 32'h0010_0000);
        rd("R8 summary set, no enabled pin", 3'd6, SPUR);
        chk("R8 irq_o low", {31'b0, irq_o}, 32'd0);
        rd("R2 summary bit 26", 3'd1, 32'h0400_0000);
        wr(3'd2, 32'hFFFF_FFFF);
        rd("R4 ones leave cause", 3'd2, 32'h0010_0000);

        // edge coincides with its clear
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'd2; bus_wdata = ~(32'h1 << 20); gpin[20] = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 3'd6; gpin[20] = 1'b0;
        rd("R4 edge beats clear", 3'd2, 32'h0010_0000);

        // disable and out-of-range commands
        wr(3'd7, 32'h00 | 33);
        rd("R9 disable source 33", 3'd4, 32'h0F00_0008);
        wr(3'd7, 32'h80 | 100);
        rd("R9 range ignore low", 3'd3, 32'h221);
        rd("R9 range ignore high", 3'd4, 32'h0F00_0008);
        rd("R9 range ignore pin", 3'd5, 32'h400);
        rd("R11 command address reads zero", 3'd7, 32'h0);
        wr(3'd5, 32'h0010_0400);
        settle();
        rd("R10 pin mask write enables source 84", 3'd6, 32'd84);

        settle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule